// File: doc/BRIEF.md
# Single-Channel SPI Port with Sticky Status Flags

This block is one SPI port that runs as a bus master or as a bus slave. A small register interface reaches it, with three selectable registers: control/status, data, and clock divider. Frames are eight bits long, most significant bit first, in SPI mode 0. The clock idles low, data is sampled on the rising edge and shifted on the falling edge.

As master, a data-register write starts a frame. SCLK is generated from the divider register, and the bits received on MISO go into a one-byte receive buffer. As slave, the block follows an external SCLK while its active-low select input is low. It shifts out a byte that software loaded in advance and captures the incoming byte.

Errors are recorded in sticky flags that only software clears: write collision, mode fault and receive overrun. A sticky transfer-complete flag is recorded the same way. A single interrupt request is raised from these flags.

Top module: `spi_port`

## Requirements
- R1: After reset the control/status register (select 0) reads 0x00, irq is low, and both output enables (mst_oe, miso_oe) are low.
- R2: Bit 7 of the control/status register (transfer complete) sets when a frame's eighth bit is shifted. Writing a 1 to it keeps its value. Writing a 0 clears it. Hardware never clears it.
- R3: Bit 3 (busy, read-only) is 1 while a master frame is in progress and returns to 0 after the frame ends.
- R4: With bit 0 (port enable) at 0, a write to the data register (select 1) starts no frame: sclk_o stays low and busy stays 0.
- R5: In master mode (bit 1 = 1), a data write sends the byte on mosi_o MSB first. mosi_o is stable at each rising sclk_o. The bits sampled from miso_i at the rising edges are readable from the data register after the frame.
- R6: In master mode, sclk_o changes level every div+1 system clocks, where div is the value written at select 2. A full SCLK period is therefore 2*(div+1) clocks.
- R7: A data write during a frame sets bit 6 (write collision). The written byte is discarded, and the frame in progress sends its original byte.
- R8: irq equals irq_en ANDed with the OR of bits 7, 6, 5 and 4.
- R9: If a frame completes while the receive buffer holds an unread byte, bit 4 (overrun) sets. The older byte stays in the data register and the new one is dropped.
- R10: When slave-select is low while master mode and port enable are set, bit 5 (mode fault) sets. The active master frame is aborted without setting bit 7, and mst_oe goes low until software clears the flag.
- R11: Bit 2 (slave selected, read-only) reads the inverse of ss_n_i, delayed by a two-flop synchronizer.
- R12: In slave mode (bit 1 = 0, bit 0 = 1) with ss_n_i low, a byte written beforehand is driven on miso_o MSB first. The byte received on mosi_i lands in the data register, bit 7 sets, and miso_oe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control/status, 1 data, 2 divider |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a data read frees the receive buffer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| mst_oe | output | 1 | Output enable for sclk_o and mosi_o |
| miso_i | input | 1 | Master serial data in |
| sclk_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench pushes a write into the data register in the middle of a frame. A design that let that write reach the shifter would put a corrupted byte on MOSI, and the scoreboard would catch it. Two frames run back to back with no read in between: a design that overwrote the buffer would return the newer byte instead of keeping the older one. Slave-select is pulled low during a master frame, which exposes a design that keeps clocking, keeps its outputs driven, or marks the aborted frame complete. Writes of 1 and of 0 to the sticky flags separate flags that clear properly from flags that clear on any write or never clear.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_en,
  output logic       irq,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       mst_oe,
  input  logic       miso_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  logic tcf, wcf, mff, ovf, msten, spien;
  logic [DIV_W-1:0] div, cnt;
  logic [7:0] sh, rxbuf;
  logic [2:0] bitcnt;
  logic rx_full, samp, xfer, sclk_q;
  logic sck1, sck2, sck3, mo1, mo2, ss1, ss2;

  wire ss_low = ~ss2;
  wire m_mode = spien & msten;
  wire s_act  = spien & ~msten & ss_low;
  wire fault  = m_mode & ss_low;
  wire abort  = ~spien | fault | (~msten & ~ss_low);
  wire wr_ctl = reg_wr && reg_sel == 2'd0;
  wire wr_dat = reg_wr && reg_sel == 2'd1;
  wire wr_div = reg_wr && reg_sel == 2'd2;
  wire rd_dat = reg_rd && reg_sel == 2'd1;
  wire collide = wr_dat & xfer;
  wire start_ok = wr_dat & ~xfer & spien & ~fault;
  wire tick   = m_mode & ~ss_low & xfer & (cnt == div);
  wire m_rise = tick & ~sclk_q;
  wire m_fall = tick & sclk_q;
  wire s_rise = s_act & sck2 & ~sck3;
  wire s_fall = s_act & ~sck2 & sck3 & xfer;
  wire do_shift = (m_fall | s_fall) & ~start_ok;
  wire last   = do_shift & (bitcnt == 3'd7);
  wire [7:0] rx_byte = {sh[6:0], samp};

  assign sclk_o  = sclk_q;
  assign mosi_o  = sh[7];
  assign miso_o  = sh[7];
  assign mst_oe  = m_mode & ~mff;
  assign miso_oe = s_act;
  assign irq     = irq_en & (tcf | wcf | mff | ovf);

  always_comb begin
    case (reg_sel)
      2'd0:    rdata = {tcf, wcf, mff, ovf, xfer & msten, ss_low, msten, spien};
      2'd1:    rdata = rxbuf;
      2'd2:    rdata = 8'(div);
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tcf, wcf, mff, ovf, msten, spien} <= '0;
      div <= '0; cnt <= '0; sh <= '0; rxbuf <= '0; bitcnt <= '0;
      {rx_full, samp, xfer, sclk_q} <= '0;
      {sck1, sck2, sck3, mo1, mo2} <= '0;
      {ss1, ss2} <= 2'b11;
    end else begin
      {sck1, sck2, sck3} <= {sclk_i, sck1, sck2};
      {mo1, mo2} <= {mosi_i, mo1};
      {ss1, ss2} <= {ss_n_i, ss1};
      if (wr_div) div <= wdata[DIV_W-1:0];
      if (wr_ctl) begin
        msten <= wdata[1];
        spien <= wdata[0];
      end
      tcf <= (wr_ctl ? tcf & wdata[7] : tcf) | last;
      wcf <= (wr_ctl ? wcf & wdata[6] : wcf) | collide;
      mff <= (wr_ctl ? mff & wdata[5] : mff) | fault;
      ovf <= (wr_ctl ? ovf & wdata[4] : ovf) | (last & rx_full);
      if (last && !rx_full) begin
        rxbuf <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_dat) rx_full <= 1'b0;

      if (start_ok) begin
        sh <= wdata;
        if (msten) begin
          xfer <= 1'b1; cnt <= '0; sclk_q <= 1'b0; bitcnt <= '0;
        end
      end else if (abort) begin
        xfer <= 1'b0; cnt <= '0; sclk_q <= 1'b0; bitcnt <= '0;
      end else begin
        if (tick) cnt <= '0;
        else if (m_mode && xfer) cnt <= cnt + 1'b1;
        if (tick) sclk_q <= ~sclk_q;
        if (s_rise) xfer <= 1'b1;
        if (m_rise) samp <= miso_i;
        else if (s_rise) samp <= mo2;
        if (do_shift) begin
          sh <= rx_byte;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) xfer <= 1'b0;
        end
      end
    end
  end

  assert_tcf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tcf && !wr_ctl) |=> tcf);
  assert_sclk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_mode && !ss_low && xfer && cnt != div) |=> $stable(sclk_o));
  assert_collide_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && xfer && !m_fall && !s_fall && !abort) |=> $stable(sh));
  assert_overrun_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_full && !rd_dat) |=> ($stable(rxbuf) && ovf));
  assert_fault_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!xfer && !mst_oe));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic reg_wr = 0, reg_rd = 0, irq_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, sclk_o, mosi_o, mst_oe, miso_o, miso_oe;
  logic miso_i = 0, sclk_i = 0, mosi_i = 0, ss_n_i = 1;
  int errs = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mpat = 0, mbyte = 0, v, cap;
  int mbits = 0;

  spi_port dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .irq(irq),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .mst_oe(mst_oe), .miso_i(miso_i),
    .sclk_i(sclk_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = rdata; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_xfer(logic [7:0] tx, logic [7:0] pat);
    exp_q.push_back(tx);
    mpat = pat; miso_i = pat[7];
    wr(2'd1, tx);
  endtask

  always @(negedge sclk_o) begin
    mpat = {mpat[6:0], 1'b0};
    miso_i = mpat[7];
  end

  always @(posedge sclk_o or negedge mst_oe) begin
    if (!mst_oe) mbits = 0;
    else begin
      mbyte = {mbyte[6:0], mosi_o};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_q.size() == 0) chk("R5 unexpected mosi frame", mbyte, 8'hxx);
        else chk("R5 mosi frame", mbyte, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    realtime t0;
    int per;
    clks(3); rst_n = 1; clks(2);
    rd(2'd0, v); chk("R1 reset status", v, 8'h00);
    chk("R1 reset irq/oe", {5'd0, irq, mst_oe, miso_oe}, 8'h00);
    irq_en = 1;

    wr(2'd2, 8'd1); wr(2'd0, 8'h03);
    master_xfer(8'hA5, 8'h3C);
    clks(3); rd(2'd0, v); chk("R3 busy during frame", v & 8'h08, 8'h08);
    clks(40);
    rd(2'd0, v); chk("R2 R3 status after frame", v, 8'h83);
    chk("R8 irq on tcf", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R5 received byte", v, 8'h3C);

    wr(2'd2, 8'd3);
    master_xfer(8'h81, 8'h7E);
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o); per = $rtoi(($realtime - t0) / 5.0 + 0.5);
    chk("R6 sclk period clocks", 8'(per), 8'd8);
    clks(80);
    rd(2'd1, v); chk("R5 received byte div3", v, 8'h7E);

    wr(2'd0, 8'hF3); rd(2'd0, v); chk("R2 write 1 keeps flag", v, 8'h83);
    wr(2'd0, 8'h03); rd(2'd0, v); chk("R2 write 0 clears flag", v, 8'h03);
    chk("R8 irq low with no flag", {7'd0, irq}, 8'h00);

    wr(2'd2, 8'd1);
    master_xfer(8'hC3, 8'h11);
    clks(6); wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R7 collision flag", v & 8'h40, 8'h40);
    chk("R7 irq on collision", {7'd0, irq}, 8'h01);
    clks(40);
    rd(2'd1, v); chk("R7 frame unaffected rx", v, 8'h11);
    wr(2'd0, 8'h03);

    master_xfer(8'h12, 8'hAB); clks(40);
    master_xfer(8'h34, 8'hCD); clks(40);
    irq_en = 0; #1 chk("R8 irq gated by enable", {7'd0, irq}, 8'h00);
    irq_en = 1;
    rd(2'd0, v); chk("R9 overrun status", v, 8'h93);
    rd(2'd1, v); chk("R9 older byte kept", v, 8'hAB);
    wr(2'd0, 8'h03);

    wr(2'd0, 8'h00); wr(2'd1, 8'h55); clks(20);
    chk("R4 disabled no sclk", {7'd0, sclk_o}, 8'h00);
    rd(2'd0, v); chk("R4 disabled status", v, 8'h00);

    wr(2'd0, 8'h03); wr(2'd2, 8'd3);
    wr(2'd1, 8'hF0); clks(12);
    ss_n_i = 0; clks(4);
    chk("R10 master outputs off", {7'd0, mst_oe}, 8'h00);
    rd(2'd0, v); chk("R10 R11 fault status", v, 8'h27);
    chk("R10 irq on fault", {7'd0, irq}, 8'h01);
    ss_n_i = 1; clks(4);
    wr(2'd0, 8'h03); clks(80);
    rd(2'd0, v); chk("R10 R11 cleared no tcf", v, 8'h03);

    wr(2'd0, 8'h01); ss_n_i = 0; clks(4);
    wr(2'd1, 8'h96); clks(2);
    cap = 0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = v[0] ^ 1'b0;
      mosi_i = 8'h5A >> i;
      clks(4);
      cap = {cap[6:0], miso_o};
      sclk_i = 1; clks(8);
      sclk_i = 0; clks(8);
    end
    clks(6);
    chk("R12 slave miso byte", cap, 8'h96);
    chk("R12 miso enabled", {7'd0, miso_oe}, 8'h01);
    rd(2'd0, v); chk("R12 R11 slave status", v, 8'h85);
    rd(2'd1, v); chk("R12 slave rx byte", v, 8'h5A);
    ss_n_i = 1; clks(4);
    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'd0);
    summary();
  end
endmodule